// File: doc/BRIEF.md
# Display Controller Register and Interrupt Unit

This block is the software-facing register file of a display controller. A bus master writes and reads word registers by byte offset. The registers cover five timing and format controls, three frame-buffer start addresses, three colour lookup words, a dither setting, a temporary palette word, a panel-select word and a three-part interrupt structure. Each register keeps only the bits defined for it. A few stored bits are decoded onto dedicated outputs that steer the pixel path: enable, pixel depth code, 5:6:5 format select and byte order.

Hardware event inputs, such as the frame-sync pulse, set bits in a source-pending register. Each cycle, the unmasked source bits are folded into the interrupt-pending register. The single interrupt line is high whenever any pending bit is set. Software clears an interrupt by clearing its source bit first and then the pending bit. If it clears the pending bit while the source bit is still set and unmasked, the pending bit is set again at once.

Reads are registered: the data appears one cycle after the read strobe. A read of an offset that decodes to no register returns zero and raises a bad-address flag for that one cycle.

Top module: `disp_regbank`

## Requirements
- R1: After reset every register reads as zero, `irq` is low, `bad_addr` is low and all decoded field outputs are zero.
- R2: Write masks: control 1 (offset 0x00) keeps bits 17:0, control 4 (0x0C) keeps bits 15:0 and control 5 (0x10) keeps bits 12:0. Read data appears on `rdata` in the cycle after `rd_en`.
- R3: `disp_en` follows bit 0 of control 1 and `pix_depth` follows bits 4:1 of control 1. `rgb565_sel` follows bit 11 of control 5 and `byte_swap` follows bit 12 of control 5.
- R4: These registers keep all 32 bits: control 2 (0x04), control 3 (0x08), the start addresses (0x14, 0x18, 0x1C), red lookup (0x20), green lookup (0x24), dither (0x4C) and temporary palette (0x50). Blue lookup (0x28) keeps bits 15:0.
- R5: Interrupt pending (0x54) and source pending (0x58) keep 2 bits on a write. The interrupt mask (0x5C) keeps 3 bits.
- R6: A write to panel select (0x60) stores bits 1:0 and sets bit 2 to one, whatever the written value.
- R7: Every cycle, pending takes its written or held value ORed with (source pending AND NOT mask bits 1:0). A masked source bit does not set pending. Clearing that mask bit later sets pending.
- R8: `irq` is high exactly when any pending bit is set.
- R9: A high `evt_in[k]` sets source-pending bit k on the next edge, with frame sync on bit 1. An event wins over a software write that clears the same bit in the same cycle.
- R10: A read of an offset that selects no register returns zero on `rdata` and raises `bad_addr` for exactly that one cycle. Offsets with bits 1:0 nonzero and gaps such as 0x30 select no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte offset |
| wdata | input | 32 | Write data |
| evt_in | input | 2 | Hardware event pulses; bit 1 is frame sync |
| rdata | output | 32 | Registered read data |
| bad_addr | output | 1 | One-cycle flag for a read of an unmapped offset |
| irq | output | 1 | Interrupt request |
| disp_en | output | 1 | Display enable field |
| pix_depth | output | 4 | Bits-per-pixel code |
| rgb565_sel | output | 1 | 5:6:5 format select |
| byte_swap | output | 1 | Byte-order select |

## Verification
The hardest case to reach from the ports is a hardware event landing in the same cycle as a software write that clears the same source bit. The bench drives the frame-sync input high inside the write cycle and reads the source and pending registers back. A second hard case is a source bit that sits latched behind its mask. The bench sets the source with its mask bit set, confirms that pending stays clear, and then clears only the mask bit. The pending bit must then appear without any new event.

// File: rtl/disp_regbank_pkg.sv
package disp_regbank_pkg;

    localparam int DW        = 32;
    localparam int NUM_REGS  = 17;
    localparam int NUM_STORE = 13;  // plain storage registers, ids 0..12

    localparam int RID_CTL1 = 0;
    localparam int RID_CTL5 = 4;
    localparam int RID_IPND = 13;
    localparam int RID_SPND = 14;
    localparam int RID_IMSK = 15;
    localparam int RID_PSEL = 16;

    // Ids 0..10 are packed from offset 0; ids 11..16 start at 0x4C.
    function automatic logic [31:0] reg_offset(input int idx);
        if (idx < 11) return 32'(idx * 4);
        else          return 32'(32'h4C + (idx - 11) * 4);
    endfunction

    function automatic logic [DW-1:0] store_mask(input int idx);
        case (idx)
            0:       return DW'(32'h0003_FFFF);
            3:       return DW'(32'h0000_FFFF);
            4:       return DW'(32'h0000_1FFF);
            10:      return DW'(32'h0000_FFFF);
            default: return '1;
        endcase
    endfunction

endpackage

// File: rtl/disp_addr_dec.sv
module disp_addr_dec
    import disp_regbank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_REGS-1:0] sel,
    output logic                hit
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_cmp
        assign sel[g] = (32'(addr) == reg_offset(g));
    end

    assign hit = |sel;

    always_comb begin
        p_sel_onehot_r10: assert ($onehot0(sel));
    end

endmodule

// File: rtl/disp_irq_unit.sv
module disp_irq_unit
    import disp_regbank_pkg::*;
#(
    parameter int N_SRC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_pnd,
    input  logic             wr_src,
    input  logic             wr_msk,
    input  logic [DW-1:0]    wdata,
    input  logic [N_SRC-1:0] evt_in,
    output logic [N_SRC-1:0] pnd_q,
    output logic [N_SRC-1:0] src_q,
    output logic [N_SRC:0]   msk_q,
    output logic             irq
);

    localparam int MASK_W = N_SRC + 1;

    typedef struct packed {
        logic [N_SRC-1:0]  pnd;
        logic [N_SRC-1:0]  src;
        logic [MASK_W-1:0] msk;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_msk) st_d.msk = wdata[MASK_W-1:0];
        if (wr_src) st_d.src = wdata[N_SRC-1:0];
        st_d.src = st_d.src | evt_in;
        if (wr_pnd) st_d.pnd = wdata[N_SRC-1:0];
        st_d.pnd = st_d.pnd | (st_d.src & ~st_d.msk[N_SRC-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pnd_q = st_q.pnd;
    assign src_q = st_q.src;
    assign msk_q = st_q.msk;
    assign irq   = |st_q.pnd;

    p_pend_covers_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.src & ~st_q.msk[N_SRC-1:0] & ~st_q.pnd) == '0));

    p_evt_sets_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_in) |=> ((st_q.src & $past(evt_in)) == $past(evt_in)));

endmodule

// File: rtl/disp_regbank.sv
module disp_regbank
    import disp_regbank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [1:0]        evt_in,
    output logic [31:0]       rdata,
    output logic              bad_addr,
    output logic              irq,
    output logic              disp_en,
    output logic [3:0]        pix_depth,
    output logic              rgb565_sel,
    output logic              byte_swap
);

    localparam int N_SRC  = 2;
    localparam int PSEL_W = 3;

    typedef struct packed {
        logic [NUM_STORE-1:0][DW-1:0] store;
        logic [PSEL_W-1:0]            psel;
        logic [DW-1:0]                rdata;
        logic                         bad;
    } bank_st_t;

    bank_st_t st_d, st_q;

    logic [NUM_REGS-1:0] sel;
    logic                hit;
    logic [N_SRC-1:0]    pnd_q, src_q;
    logic [N_SRC:0]      msk_q;
    logic [DW-1:0]       rd_mux;

    disp_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (addr),
        .sel  (sel),
        .hit  (hit)
    );

    disp_irq_unit #(.N_SRC(N_SRC)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_pnd (wr_en && sel[RID_IPND]),
        .wr_src (wr_en && sel[RID_SPND]),
        .wr_msk (wr_en && sel[RID_IMSK]),
        .wdata  (wdata),
        .evt_in (evt_in),
        .pnd_q  (pnd_q),
        .src_q  (src_q),
        .msk_q  (msk_q),
        .irq    (irq)
    );

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_STORE; i++) begin
            if (sel[i]) rd_mux = rd_mux | st_q.store[i];
        end
        if (sel[RID_IPND]) rd_mux = rd_mux | DW'(pnd_q);
        if (sel[RID_SPND]) rd_mux = rd_mux | DW'(src_q);
        if (sel[RID_IMSK]) rd_mux = rd_mux | DW'(msk_q);
        if (sel[RID_PSEL]) rd_mux = rd_mux | DW'(st_q.psel);
    end

    always_comb begin
        st_d     = st_q;
        st_d.bad = 1'b0;
        if (wr_en) begin
            for (int i = 0; i < NUM_STORE; i++) begin
                if (sel[i]) st_d.store[i] = wdata & store_mask(i);
            end
            if (sel[RID_PSEL]) st_d.psel = {1'b1, wdata[1:0]};
        end
        if (rd_en) begin
            st_d.rdata = rd_mux;
            st_d.bad   = !hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata      = st_q.rdata;
    assign bad_addr   = st_q.bad;
    assign disp_en    = st_q.store[RID_CTL1][0];
    assign pix_depth  = st_q.store[RID_CTL1][4:1];
    assign rgb565_sel = st_q.store[RID_CTL5][11];
    assign byte_swap  = st_q.store[RID_CTL5][12];

    p_psel_bit2_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel[RID_PSEL]) |=> st_q.psel[2]);

    p_bad_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bad_addr |-> (rdata == '0));

    p_ctl1_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel[RID_CTL1]) |=> (disp_en == $past(wdata[0])));

endmodule

// File: tb/disp_regbank_tb.sv
module disp_regbank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [1:0]  evt_in = '0;
    logic [31:0] rdata;
    logic        bad_addr, irq, disp_en, rgb565_sel, byte_swap;
    logic [3:0]  pix_depth;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    disp_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .evt_in(evt_in), .rdata(rdata), .bad_addr(bad_addr),
        .irq(irq), .disp_en(disp_en), .pix_depth(pix_depth),
        .rgb565_sel(rgb565_sel), .byte_swap(byte_swap)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic b);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata; b = bad_addr;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d; logic b;
        rd(a, d, b);
        check(req, d, exp);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 17; i++) begin
            rd_chk("R1", (i < 11) ? 8'(i * 4) : 8'(8'h4C + (i - 11) * 4), 32'h0);
        end
        check("R1 irq", 32'(irq), 0);
        check("R1 fields", {disp_en, pix_depth, rgb565_sel, byte_swap}, 0);
    endtask

    task automatic t_masks();
        wr(8'h00, 32'hFFFF_FFFF); rd_chk("R2 ctl1", 8'h00, 32'h0003_FFFF);
        wr(8'h0C, 32'hFFFF_FFFF); rd_chk("R2 ctl4", 8'h0C, 32'h0000_FFFF);
        wr(8'h10, 32'hFFFF_FFFF); rd_chk("R2 ctl5", 8'h10, 32'h0000_1FFF);
    endtask

    task automatic t_fields();
        wr(8'h00, 32'h0000_0013);
        check("R3 en", 32'(disp_en), 1);
        check("R3 depth", 32'(pix_depth), 9);
        wr(8'h10, 32'h0000_1800);
        check("R3 565+order", {rgb565_sel, byte_swap}, 32'h3);
        wr(8'h10, 32'h0000_0800);
        check("R3 565 only", {rgb565_sel, byte_swap}, 32'h2);
        wr(8'h00, 32'h0000_000A);
        check("R3 en off", {disp_en, pix_depth}, 32'h05);
    endtask

    task automatic t_full();
        logic [7:0] offs [8] = '{8'h04, 8'h08, 8'h14, 8'h18, 8'h1C, 8'h20, 8'h24, 8'h4C};
        for (int i = 0; i < 8; i++) wr(offs[i], 32'hA5C3_0000 ^ (32'(i) * 32'h0101_0F0F));
        for (int i = 0; i < 8; i++) rd_chk("R4", offs[i], 32'hA5C3_0000 ^ (32'(i) * 32'h0101_0F0F));
        wr(8'h50, 32'hDEAD_BEEF); rd_chk("R4 tpal", 8'h50, 32'hDEAD_BEEF);
        wr(8'h28, 32'hFFFF_FFFF); rd_chk("R4 blue", 8'h28, 32'h0000_FFFF);
    endtask

    task automatic t_irq();
        wr(8'h54, 32'hFFFF_FFFF); rd_chk("R5 pend", 8'h54, 32'h3);
        check("R8 irq high", 32'(irq), 1);
        wr(8'h54, 0);
        check("R8 irq low", 32'(irq), 0);
        wr(8'h5C, 32'hFFFF_FFFF); rd_chk("R5 mask", 8'h5C, 32'h7);
        wr(8'h58, 32'hFFFF_FFFF); rd_chk("R5 src", 8'h58, 32'h3);
        rd_chk("R7 masked", 8'h54, 32'h0);
        check("R8 masked irq", 32'(irq), 0);
        wr(8'h5C, 32'h5);
        rd_chk("R7 unmask", 8'h54, 32'h2);
        check("R8 unmask irq", 32'(irq), 1);
        wr(8'h54, 0);
        rd_chk("R7 reassert", 8'h54, 32'h2);
        wr(8'h58, 0); wr(8'h54, 0); wr(8'h5C, 0);
        check("R8 cleared", 32'(irq), 0);
    endtask

    task automatic t_psel();
        wr(8'h60, 32'h0);         rd_chk("R6 zero", 8'h60, 32'h4);
        wr(8'h60, 32'hFFFF_FFFB); rd_chk("R6 ones", 8'h60, 32'h7);
        wr(8'h60, 32'h1);         rd_chk("R6 one", 8'h60, 32'h5);
    endtask

    task automatic t_event();
        @(negedge clk); evt_in = 2'b10;
        @(negedge clk); evt_in = 2'b00;
        check("R9 irq", 32'(irq), 1);
        rd_chk("R9 src", 8'h58, 32'h2);
        rd_chk("R9 pend", 8'h54, 32'h2);
        wr(8'h58, 0); wr(8'h54, 0);
        check("R9 cleared", 32'(irq), 0);
        @(negedge clk); wr_en = 1'b1; addr = 8'h58; wdata = 0; evt_in = 2'b10;
        @(negedge clk); wr_en = 1'b0; evt_in = 2'b00;
        rd_chk("R9 race", 8'h58, 32'h2);
        wr(8'h58, 0); wr(8'h54, 0); wr(8'h5C, 32'h2);
        @(negedge clk); evt_in = 2'b10;
        @(negedge clk); evt_in = 2'b00;
        rd_chk("R9 masked src", 8'h58, 32'h2);
        check("R9 masked irq", 32'(irq), 0);
        wr(8'h58, 0); wr(8'h5C, 0);
    endtask

    task automatic t_bad();
        logic [31:0] d; logic b;
        rd(8'h00, d, b);
        check("R10 good flag", 32'(b), 0);
        rd(8'h30, d, b);
        check("R10 gap data", d, 0);
        check("R10 gap flag", 32'(b), 1);
        @(negedge clk);
        check("R10 pulse", 32'(bad_addr), 0);
        rd(8'h02, d, b);
        check("R10 misaligned", 32'(b), 1);
        wr(8'h30, 32'hFFFF_FFFF);
        rd_chk("R10 ctl1 intact", 8'h00, 32'h0000_000A);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_masks();
        t_fields();
        t_full();
        t_irq();
        t_psel();
        t_event();
        t_bad();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule